// File: doc/BRIEF.md
# I2C Register-Access Slave

This block is an I2C target that lets a bus controller reach a small register file through an internal byte pointer. In a write frame, the first byte after the device address loads the pointer. Each later data byte is stored at the pointer, and the pointer then steps up by one. In a read frame, bytes are sent from the pointer onward, MSB first, and the pointer advances after each byte. A STOP that closes a read returns the pointer to address 0. Address 0 shows a live status byte taken from the `status_i` input, so software can poll it without rewriting the pointer.

A reset can be requested in two ways: by writing a reserved pointer value, or by sending a general-call command byte. Either request reloads every stored register with its default value. A hold-off interval then follows, during which the block acknowledges nothing on the bus. SCL and SDA are oversampled by the system clock. SDA is open-drain, so the block only asserts a pull-low enable. The block never stretches the clock.

Top module: `regport_i2c_slave`

## Requirements
- R1: An address byte whose upper 7 bits equal `DEV_ADDR` is acknowledged, with its LSB giving direction (1 = read, 0 = write). Any other address byte except the general call is not acknowledged.
- R2: In a write frame, the first byte after the address is acknowledged and loads the pointer. Each following data byte is acknowledged, stored at the pointer, and the pointer then increments.
- R3: In a read frame, bytes are shifted out MSB first from the pointer, and the pointer increments after each byte. The block keeps sending while the controller drives ACK (SDA low) in the acknowledge slot. After a NACK (SDA high) it drives nothing more.
- R4: A STOP that ends a read frame sets the pointer to 0. A following read without a pointer write returns `status_i`, which is the value of address 0.
- R5: A byte written to a location that is out of range, invalid (`VALID_MASK` bit clear), read-only (`WRITE_MASK` bit clear) or address 0 is acknowledged but not stored. Reads of out-of-range or invalid locations return 0x00.
- R6: A pointer byte of 0xBF is acknowledged and reloads every stored register i to `DEFAULT_BASE + i`.
- R7: Address byte 0x00 (general call, write) is acknowledged. A command byte of 0x06 is then acknowledged and reloads the defaults. Any other command byte is not acknowledged and changes no register.
- R8: After a reload, `reset_busy_o` stays high for exactly `CLK_HZ/1e6 * BLACKOUT_US` clock cycles. While it is high, no address byte is acknowledged and SDA is never driven.
- R9: The SDA enable changes only after a detected SCL falling edge, or on START/STOP. The block never drives SDA while the controller sends the data bits of a byte.
- R10: After reset, SDA is released, `reset_busy_o` is low, every stored register holds its default value, and the pointer is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock that oversamples the bus |
| rst_n | input | 1 | Asynchronous active-low reset |
| scl_i | input | 1 | Bus clock line level |
| sda_i | input | 1 | Bus data line level |
| status_i | input | 8 | Live status value read at address 0 |
| sda_oe_o | output | 1 | Pull SDA low when high |
| reset_busy_o | output | 1 | High during the post-reload hold-off |
| regs_o | output | 8*REG_DEPTH | Current value of every register, address i at bits [8i+7:8i] |

## Verification
The bench builds the block with `CLK_HZ` = 4 MHz and `BLACKOUT_US` = 100. This gives a 400-cycle hold-off: long enough that a full address byte can be sent, and refused, inside it, and short enough that its exact length can be measured. It keeps the depth at 8, with address 7 invalid and address 5 read-only. A single burst can therefore write a stored cell, a read-only cell, an invalid cell and an out-of-range location, and one read can run from stored data into the zero-returning region. Bus bits are 20 system clocks long, so the synchronizer latency sits well inside each SCL phase.

// File: rtl/regport_pkg.sv
package regport_pkg;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_ADDR,
        ST_SUB,
        ST_WDATA,
        ST_GCMD,
        ST_ACK,
        ST_TX,
        ST_MACK
    } slv_state_e;

    typedef struct packed {
        slv_state_e state;
        slv_state_e after;
        logic       reload_after;
        logic [3:0] cnt;
        logic [7:0] shreg;
        logic [7:0] txreg;
        logic [7:0] ptr;
        logic       sda_oe;
        logic       in_read;
    } slv_regs_t;

endpackage

// File: rtl/regport_pin_sync.sv
module regport_pin_sync (
    input  logic clk,
    input  logic rst_n,
    input  logic scl_i,
    input  logic sda_i,
    output logic scl_s,
    output logic sda_s,
    output logic scl_rise,
    output logic scl_fall,
    output logic start_det,
    output logic stop_det
);
    // [0] metastability stage, [1] synced, [2] previous synced
    logic [2:0] scl_d, scl_q;
    logic [2:0] sda_d, sda_q;

    always_comb begin
        scl_d = {scl_q[1:0], scl_i};
        sda_d = {sda_q[1:0], sda_i};
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            scl_q <= 3'b111;
            sda_q <= 3'b111;
        end else begin
            scl_q <= scl_d;
            sda_q <= sda_d;
        end
    end

    assign scl_s     = scl_q[1];
    assign sda_s     = sda_q[1];
    assign scl_rise  = scl_q[1] & ~scl_q[2];
    assign scl_fall  = ~scl_q[1] & scl_q[2];
    assign start_det = scl_q[1] & scl_q[2] & sda_q[2] & ~sda_q[1];
    assign stop_det  = scl_q[1] & scl_q[2] & ~sda_q[2] & sda_q[1];

endmodule

// File: rtl/regport_blackout.sv
module regport_blackout #(
    parameter int CYCLES = 7500
) (
    input  logic clk,
    input  logic rst_n,
    input  logic trigger_i,
    output logic busy_o
);
    localparam int CW = $clog2(CYCLES + 1);

    logic [CW-1:0] cnt_d, cnt_q;

    always_comb begin
        cnt_d = cnt_q;
        if (trigger_i)
            cnt_d = CW'(CYCLES);
        else if (cnt_q != '0)
            cnt_d = cnt_q - 1'b1;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) cnt_q <= '0;
        else        cnt_q <= cnt_d;
    end

    assign busy_o = (cnt_q != '0);

    // R8: hold-off starts only from a reload request
    a_r8_busy_from_trigger: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(busy_o) |-> $past(trigger_i));

    // R8: a request always opens the hold-off on the next cycle
    a_r8_trigger_opens: assert property (@(posedge clk) disable iff (!rst_n)
        trigger_i |=> busy_o);

endmodule

// File: rtl/regport_regfile.sv
module regport_regfile #(
    parameter int                    REG_DEPTH    = 8,
    parameter logic [REG_DEPTH-1:0]  VALID_MASK   = 8'h7F,
    parameter logic [REG_DEPTH-1:0]  WRITE_MASK   = 8'h5E,
    parameter logic [7:0]            DEFAULT_BASE = 8'h30
) (
    input  logic                   clk,
    input  logic                   rst_n,
    input  logic                   reload_i,
    input  logic                   wr_en_i,
    input  logic [7:0]             wr_addr_i,
    input  logic [7:0]             wr_data_i,
    input  logic [7:0]             rd_addr_i,
    input  logic [7:0]             status_i,
    output logic [7:0]             rd_data_o,
    output logic [8*REG_DEPTH-1:0] regs_o
);
    logic wr_ok;

    always_comb begin
        wr_ok = 1'b0;
        for (int i = 1; i < REG_DEPTH; i++)
            if (int'(wr_addr_i) == i && VALID_MASK[i] && WRITE_MASK[i])
                wr_ok = 1'b1;
    end

    for (genvar i = 0; i < REG_DEPTH; i++) begin : g_cell
        localparam logic [7:0] DFLT = 8'(DEFAULT_BASE + 8'(i));
        if (i == 0) begin : g_status
            assign regs_o[7:0] = status_i;
        end else if (VALID_MASK[i] && WRITE_MASK[i]) begin : g_rw
            logic [7:0] val_d, val_q;
            always_comb begin
                val_d = val_q;
                if (reload_i)
                    val_d = DFLT;
                else if (wr_en_i && int'(wr_addr_i) == i)
                    val_d = wr_data_i;
            end
            always_ff @(posedge clk or negedge rst_n) begin
                if (!rst_n) val_q <= DFLT;
                else        val_q <= val_d;
            end
            assign regs_o[8*i +: 8] = val_q;
        end else if (VALID_MASK[i]) begin : g_ro
            assign regs_o[8*i +: 8] = DFLT;
        end else begin : g_hole
            assign regs_o[8*i +: 8] = 8'h00;
        end
    end

    always_comb begin
        rd_data_o = 8'h00;
        for (int i = 0; i < REG_DEPTH; i++)
            if (int'(rd_addr_i) == i && VALID_MASK[i])
                rd_data_o = regs_o[8*i +: 8];
    end

    // R5: a write aimed at a location that cannot take it leaves every stored cell as it was
    a_r5_discard_write: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en_i && !wr_ok && !reload_i) |=> $stable(regs_o[8*REG_DEPTH-1:8]));

endmodule

// File: rtl/regport_i2c_slave.sv
module regport_i2c_slave
    import regport_pkg::*;
#(
    parameter logic [6:0]            DEV_ADDR     = 7'h48,
    parameter int                    REG_DEPTH    = 8,
    parameter logic [REG_DEPTH-1:0]  VALID_MASK   = 8'h7F,
    parameter logic [REG_DEPTH-1:0]  WRITE_MASK   = 8'h5E,
    parameter logic [7:0]            DEFAULT_BASE = 8'h30,
    parameter int                    CLK_HZ       = 50_000_000,
    parameter int                    BLACKOUT_US  = 150,
    parameter logic [7:0]            RESET_CMD    = 8'hBF,
    parameter logic [7:0]            GC_RESET_CMD = 8'h06
) (
    input  logic                   clk,
    input  logic                   rst_n,
    input  logic                   scl_i,
    input  logic                   sda_i,
    input  logic [7:0]             status_i,
    output logic                   sda_oe_o,
    output logic                   reset_busy_o,
    output logic [8*REG_DEPTH-1:0] regs_o
);
    localparam int BLACKOUT_CYCLES = (CLK_HZ / 1_000_000) * BLACKOUT_US;

    logic scl_s, sda_s, scl_rise, scl_fall, start_det, stop_det;
    logic busy;
    logic wr_en, reload;
    logic [7:0] rd_data;
    slv_regs_t cur, nxt;

    regport_pin_sync u_sync (
        .clk       (clk),
        .rst_n     (rst_n),
        .scl_i     (scl_i),
        .sda_i     (sda_i),
        .scl_s     (scl_s),
        .sda_s     (sda_s),
        .scl_rise  (scl_rise),
        .scl_fall  (scl_fall),
        .start_det (start_det),
        .stop_det  (stop_det)
    );

    regport_blackout #(.CYCLES(BLACKOUT_CYCLES)) u_blackout (
        .clk       (clk),
        .rst_n     (rst_n),
        .trigger_i (reload),
        .busy_o    (busy)
    );

    regport_regfile #(
        .REG_DEPTH    (REG_DEPTH),
        .VALID_MASK   (VALID_MASK),
        .WRITE_MASK   (WRITE_MASK),
        .DEFAULT_BASE (DEFAULT_BASE)
    ) u_regfile (
        .clk       (clk),
        .rst_n     (rst_n),
        .reload_i  (reload),
        .wr_en_i   (wr_en),
        .wr_addr_i (cur.ptr),
        .wr_data_i (cur.shreg),
        .rd_addr_i (cur.ptr),
        .status_i  (status_i),
        .rd_data_o (rd_data),
        .regs_o    (regs_o)
    );

    always_comb begin
        logic [3:0] cnt_n;
        logic [7:0] tx_sh;
        logic       give_ack;
        nxt      = cur;
        wr_en    = 1'b0;
        reload   = 1'b0;
        give_ack = 1'b0;
        cnt_n    = cur.cnt + 4'd1;
        tx_sh    = {cur.txreg[6:0], 1'b0};

        if (start_det) begin
            nxt.state  = ST_ADDR;
            nxt.cnt    = '0;
            nxt.sda_oe = 1'b0;
        end else if (stop_det) begin
            nxt.state  = ST_IDLE;
            nxt.sda_oe = 1'b0;
            if (cur.in_read) begin
                nxt.ptr     = 8'h00;
                nxt.in_read = 1'b0;
            end
        end else begin
            unique case (cur.state)
                ST_ADDR, ST_SUB, ST_WDATA, ST_GCMD: begin
                    if (scl_rise && cur.cnt < 4'd8) begin
                        nxt.shreg = {cur.shreg[6:0], sda_s};
                        nxt.cnt   = cnt_n;
                    end else if (scl_fall && cur.cnt == 4'd8) begin
                        nxt.cnt = '0;
                        unique case (cur.state)
                            ST_ADDR: begin
                                if (!busy && cur.shreg[7:1] == DEV_ADDR) begin
                                    give_ack    = 1'b1;
                                    nxt.after   = cur.shreg[0] ? ST_TX : ST_SUB;
                                    if (cur.shreg[0]) nxt.in_read = 1'b1;
                                end else if (!busy && cur.shreg == 8'h00) begin
                                    give_ack  = 1'b1;
                                    nxt.after = ST_GCMD;
                                end else begin
                                    nxt.state = ST_IDLE;
                                end
                            end
                            ST_SUB: begin
                                give_ack = 1'b1;
                                if (cur.shreg == RESET_CMD) begin
                                    nxt.reload_after = 1'b1;
                                    nxt.after        = ST_IDLE;
                                end else begin
                                    nxt.ptr   = cur.shreg;
                                    nxt.after = ST_WDATA;
                                end
                            end
                            ST_WDATA: begin
                                give_ack  = 1'b1;
                                wr_en     = 1'b1;
                                nxt.ptr   = cur.ptr + 8'd1;
                                nxt.after = ST_WDATA;
                            end
                            default: begin
                                if (cur.shreg == GC_RESET_CMD) begin
                                    give_ack         = 1'b1;
                                    nxt.reload_after = 1'b1;
                                    nxt.after        = ST_IDLE;
                                end else begin
                                    nxt.state = ST_IDLE;
                                end
                            end
                        endcase
                        if (give_ack) begin
                            nxt.state  = ST_ACK;
                            nxt.sda_oe = 1'b1;
                        end
                    end
                end
                ST_ACK: begin
                    if (scl_fall) begin
                        nxt.sda_oe       = 1'b0;
                        nxt.reload_after = 1'b0;
                        nxt.cnt          = '0;
                        if (cur.reload_after) begin
                            reload      = 1'b1;
                            nxt.ptr     = 8'h00;
                            nxt.in_read = 1'b0;
                            nxt.state   = ST_IDLE;
                        end else begin
                            nxt.state = cur.after;
                            if (cur.after == ST_TX) begin
                                nxt.txreg  = rd_data;
                                nxt.sda_oe = ~rd_data[7];
                            end
                        end
                    end
                end
                ST_TX: begin
                    if (scl_fall) begin
                        if (cnt_n == 4'd8) begin
                            nxt.cnt    = '0;
                            nxt.sda_oe = 1'b0;
                            nxt.ptr    = cur.ptr + 8'd1;
                            nxt.state  = ST_MACK;
                        end else begin
                            nxt.cnt    = cnt_n;
                            nxt.txreg  = tx_sh;
                            nxt.sda_oe = ~tx_sh[7];
                        end
                    end
                end
                ST_MACK: begin
                    if (scl_rise) begin
                        if (sda_s) nxt.state = ST_IDLE;
                        else       nxt.cnt   = 4'd1;
                    end else if (scl_fall && cur.cnt == 4'd1) begin
                        nxt.cnt    = '0;
                        nxt.txreg  = rd_data;
                        nxt.sda_oe = ~rd_data[7];
                        nxt.state  = ST_TX;
                    end
                end
                default: ;
            endcase
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cur <= '{state: ST_IDLE, after: ST_IDLE, reload_after: 1'b0,
                     cnt: '0, shreg: '0, txreg: '0, ptr: '0,
                     sda_oe: 1'b0, in_read: 1'b0};
        end else begin
            cur <= nxt;
        end
    end

    assign sda_oe_o     = cur.sda_oe;
    assign reset_busy_o = busy;

    // R9: drive level moves only after an SCL fall seen by the front end, or on START/STOP
    a_r9_sda_moves_on_low: assert property (@(posedge clk) disable iff (!rst_n)
        (nxt.sda_oe != cur.sda_oe) |-> (scl_fall || start_det || stop_det));

    // R8: nothing is driven on the bus during the hold-off
    a_r8_quiet_when_busy: assert property (@(posedge clk) disable iff (!rst_n)
        busy |-> !cur.sda_oe);

    // R4: STOP after a read returns the pointer to the status location
    a_r4_stop_rewinds: assert property (@(posedge clk) disable iff (!rst_n)
        (stop_det && cur.in_read) |=> (cur.ptr == 8'h00));

    // R6: a reload always leaves the pointer at 0
    a_r6_reload_rewinds: assert property (@(posedge clk) disable iff (!rst_n)
        reload |=> (cur.ptr == 8'h00 && busy));

endmodule

// File: tb/regport_i2c_slave_bench.sv
module regport_i2c_slave_bench;
    localparam int CLK_PERIOD = 10;
    localparam int Q          = 5;
    localparam int DEPTH      = 8;
    localparam int BLACKOUT   = 400;
    localparam logic [6:0] DEV = 7'h48;
    localparam logic [7:0] STATUS = 8'h5A;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic m_scl = 1'b1;
    logic m_sda_low = 1'b0;
    logic sda_oe_o, reset_busy_o;
    logic [8*DEPTH-1:0] regs_o;
    logic [7:0] status = STATUS;
    wire sda_line = !(m_sda_low || sda_oe_o);

    int n_chk = 0, n_fail = 0;
    bit quiet = 1'b0;
    int busy_run = 0, last_run = 0;
    logic [7:0] mreg [DEPTH];

    always #(CLK_PERIOD/2) clk = ~clk;

    regport_i2c_slave #(
        .DEV_ADDR(DEV), .REG_DEPTH(DEPTH), .VALID_MASK(8'h7F), .WRITE_MASK(8'h5E),
        .DEFAULT_BASE(8'h30), .CLK_HZ(4_000_000), .BLACKOUT_US(100)
    ) u_regport_i2c_slave (
        .clk(clk), .rst_n(rst_n), .scl_i(m_scl), .sda_i(sda_line),
        .status_i(status), .sda_oe_o(sda_oe_o), .reset_busy_o(reset_busy_o),
        .regs_o(regs_o)
    );

    task automatic chk(input bit ok, input string tag, input int act, input int exp);
        n_chk++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    // R9: slave must stay off SDA while the controller sends data bits
    always @(negedge clk) begin
        if (rst_n && quiet) chk(!sda_oe_o, "R9 drive during controller bits", sda_oe_o, 0);
    end

    // R8: length of each hold-off in cycles
    always @(negedge clk) begin
        if (reset_busy_o) busy_run++;
        else if (busy_run != 0) begin
            last_run = busy_run;
            busy_run = 0;
        end
    end

    task automatic wq;
        repeat (Q) @(negedge clk);
    endtask

    task automatic model_defaults;
        for (int i = 0; i < DEPTH; i++)
            mreg[i] = (i == 7) ? 8'h00 : 8'(8'h30 + i);
    endtask

    function automatic logic [7:0] model_rd(input int a);
        if (a == 0) return status;
        if (a >= DEPTH || a == 7) return 8'h00;
        return mreg[a];
    endfunction

    task automatic check_regs(input string tag);
        for (int i = 0; i < DEPTH; i++)
            chk(regs_o[8*i +: 8] == model_rd(i), tag, regs_o[8*i +: 8], model_rd(i));
    endtask

    task automatic bstart;
        m_sda_low = 1'b0; wq;
        m_scl = 1'b1; wq;
        m_sda_low = 1'b1; wq;
        m_scl = 1'b0; wq;
    endtask

    task automatic bstop;
        m_sda_low = 1'b1; wq;
        m_scl = 1'b1; wq;
        m_sda_low = 1'b0; wq;
    endtask

    task automatic send_byte(input logic [7:0] b, output bit ack);
        for (int i = 7; i >= 0; i--) begin
            wq; quiet = 1'b1;
            m_sda_low = !b[i]; wq;
            m_scl = 1'b1; wq; wq;
            m_scl = 1'b0;
        end
        quiet = 1'b0;
        wq; m_sda_low = 1'b0; wq;
        m_scl = 1'b1; wq;
        ack = !sda_line; wq;
        m_scl = 1'b0;
    endtask

    task automatic recv_byte(output logic [7:0] b, input bit mack);
        b = 8'h00;
        for (int i = 0; i < 8; i++) begin
            wq; wq;
            m_scl = 1'b1; wq;
            b = {b[6:0], sda_line}; wq;
            m_scl = 1'b0;
        end
        wq; m_sda_low = mack; wq;
        m_scl = 1'b1; wq; wq;
        m_scl = 1'b0; wq;
        m_sda_low = 1'b0;
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        chk(1'b0, "watchdog expired", 0, 1);
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end

    initial begin
        bit ack;
        logic [7:0] rb;
        model_defaults();
        repeat (4) @(negedge clk);
        rst_n = 1'b1;
        repeat (4) @(negedge clk);

        // R10: reset state
        chk(!sda_oe_o, "R10 sda released", sda_oe_o, 0);
        chk(!reset_busy_o, "R10 busy low", reset_busy_o, 0);
        check_regs("R10 default contents");

        // R1 / R2: write burst at pointer 2
        bstart;
        send_byte({DEV, 1'b0}, ack); chk(ack, "R1 own address write ack", ack, 1);
        send_byte(8'h02, ack);       chk(ack, "R2 pointer byte ack", ack, 1);
        send_byte(8'hA5, ack);       chk(ack, "R2 data ack", ack, 1);
        send_byte(8'h3C, ack);       chk(ack, "R2 data ack", ack, 1);
        bstop;
        mreg[2] = 8'hA5; mreg[3] = 8'h3C;
        check_regs("R2 stored burst");

        // R1: foreign address
        bstart;
        send_byte({7'h21, 1'b0}, ack); chk(!ack, "R1 foreign address nack", ack, 0);
        bstop;
        check_regs("R1 foreign address no effect");

        // R5: read-only, stored, invalid, out-of-range, and address 0
        bstart;
        send_byte({DEV, 1'b0}, ack);
        send_byte(8'h05, ack);
        send_byte(8'h99, ack); chk(ack, "R5 read-only write ack", ack, 1);
        send_byte(8'h11, ack); chk(ack, "R5 stored write ack", ack, 1);
        send_byte(8'h22, ack); chk(ack, "R5 invalid write ack", ack, 1);
        send_byte(8'h33, ack); chk(ack, "R5 out-of-range write ack", ack, 1);
        bstop;
        mreg[6] = 8'h11;
        check_regs("R5 discarded writes");
        bstart;
        send_byte({DEV, 1'b0}, ack);
        send_byte(8'h00, ack);
        send_byte(8'hEE, ack); chk(ack, "R5 address 0 write ack", ack, 1);
        bstop;
        check_regs("R5 address 0 not stored");

        // R3: read burst from pointer 2 after repeated START
        bstart;
        send_byte({DEV, 1'b0}, ack);
        send_byte(8'h02, ack);
        bstart;
        send_byte({DEV, 1'b1}, ack); chk(ack, "R1 own address read ack", ack, 1);
        recv_byte(rb, 1'b1); chk(rb == model_rd(2), "R3 read byte 0", rb, model_rd(2));
        recv_byte(rb, 1'b1); chk(rb == model_rd(3), "R3 read byte 1", rb, model_rd(3));
        recv_byte(rb, 1'b0); chk(rb == model_rd(4), "R3 read byte 2", rb, model_rd(4));
        wq;
        chk(!sda_oe_o, "R3 released after nack", sda_oe_o, 0);
        bstop;

        // R4: poll status after the STOP
        bstart;
        send_byte({DEV, 1'b1}, ack);
        recv_byte(rb, 1'b0); chk(rb == STATUS, "R4 status poll", rb, STATUS);
        bstop;
        bstart;
        send_byte({DEV, 1'b1}, ack);
        recv_byte(rb, 1'b0); chk(rb == STATUS, "R4 status poll again", rb, STATUS);
        bstop;

        // R5: reads of invalid and out-of-range locations
        bstart;
        send_byte({DEV, 1'b0}, ack);
        send_byte(8'h07, ack);
        bstart;
        send_byte({DEV, 1'b1}, ack);
        recv_byte(rb, 1'b1); chk(rb == 8'h00, "R5 invalid read", rb, 0);
        recv_byte(rb, 1'b0); chk(rb == 8'h00, "R5 out-of-range read", rb, 0);
        bstop;

        // R6 / R8: pointer-byte reset command
        bstart;
        send_byte({DEV, 1'b0}, ack);
        send_byte(8'hBF, ack); chk(ack, "R6 reset command ack", ack, 1);
        bstop;
        model_defaults();
        chk(reset_busy_o, "R8 busy after reset command", reset_busy_o, 1);
        check_regs("R6 defaults reloaded");
        bstart;
        send_byte({DEV, 1'b0}, ack); chk(!ack, "R8 no ack while busy", ack, 0);
        bstop;
        while (reset_busy_o) @(negedge clk);
        @(negedge clk);
        chk(last_run == BLACKOUT, "R8 hold-off length", last_run, BLACKOUT);

        // R7: general call with an unknown command, then with the reset command
        bstart;
        send_byte({DEV, 1'b0}, ack); chk(ack, "R8 ack after hold-off", ack, 1);
        send_byte(8'h03, ack);
        send_byte(8'h77, ack);
        bstop;
        mreg[3] = 8'h77;
        bstart;
        send_byte(8'h00, ack); chk(ack, "R7 general call ack", ack, 1);
        send_byte(8'h09, ack); chk(!ack, "R7 other command nack", ack, 0);
        bstop;
        chk(!reset_busy_o, "R7 no hold-off for other command", reset_busy_o, 0);
        check_regs("R7 other command no effect");
        bstart;
        send_byte(8'h00, ack);
        send_byte(8'h06, ack); chk(ack, "R7 reset command ack", ack, 1);
        bstop;
        model_defaults();
        chk(reset_busy_o, "R7 hold-off after general call", reset_busy_o, 1);
        check_regs("R7 defaults reloaded");
        while (reset_busy_o) @(negedge clk);
        @(negedge clk);
        chk(last_run == BLACKOUT, "R8 hold-off length after general call", last_run, BLACKOUT);

        repeat (10) @(negedge clk);
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end

endmodule